// File: doc/BRIEF.md
# One-Time Fuse Trim Register Bank

This block holds the trim settings of a sensor front end as a small bank of one-time-programmable registers. Three of the registers carry trim data: a 9-bit gain trim, a 9-bit zero-field duty trim and a 5-bit carrier trim. A fourth, single-bit register is the global lock. Each data register combines two kinds of storage. Its fuse bits can only ever be set and are cleared by nothing except a factory-fresh reset. Its volatile trial code is lost whenever the supply is cycled. The value driven to the analog trim inputs is the bitwise OR of the two.

A programming sequencer elsewhere decodes the supply pulse protocol. It presents a register select, an addressed code, a mode, a code-load strobe and a blow strobe. A blow sets exactly one fuse bit. A multi-bit code is therefore built up over several blows, with a supply cycle between them, in whatever bit order is wanted. Blowing the lock fuse freezes all further programming. Illegal blow requests are refused and flagged for one cycle. Two resets model the physics. `rst_n` stands for a supply cycle and clears only volatile state. `fuse_rst_n` stands for a virgin die and clears the fuse storage.

Top module: `fuse_trim_bank`

## Requirements
- R1: While `rst_n` is low the trial codes and `blow_err` are 0, and the fuse bits keep their values. While `fuse_rst_n` is low every fuse bit, including the lock, is 0.
- R2: Each trim output equals the bitwise OR of that register's fuse bits and its trial code. The widths are 9 bits for `gain_trim`, 9 bits for `zero_trim` and 5 bits for `carrier_trim`.
- R3: When `code_load` is high, `mode` is 1 (trial) or 2 (program), the bank is not locked and `reg_sel` is 1 (gain), 2 (zero) or 3 (carrier), the low bits of `code` replace that register's trial code. The output shows the new code from the next cycle. In every other case `code_load` has no effect.
- R4: A blow request is legal when `mode` is 2, the bank is not locked, `reg_sel` is 1, 2 or 3, and `code` has exactly one bit set at a position inside that register's width. A legal blow sets that single fuse bit from the next cycle.
- R5: A fuse bit that has been set is never cleared by `rst_n`. Bits of one register may be set in any order and accumulate; for example, blowing bit 1 and then bit 0 gives 3.
- R6: An illegal blow request changes no fuse bit. `blow_err` is high for exactly the one cycle after each illegal request. Illegal requests include a code with zero bits or two or more bits set, a code bit above the register's width, a `mode` other than 2, and a request while locked.
- R7: A legal blow with `reg_sel` = 6 and `code` = 512 (bit 9 alone) sets `locked` from the next cycle. A blow to select 6 with any other code is illegal. After lock, every code load and every blow is ignored, and each blow request raises `blow_err`.
- R8: `locked` and all fuse bits survive a pulse on `rst_n`. After such a pulse each trim output equals its fuse bits alone.
- R9: A blow request with `reg_sel` 0, 4, 5 or 7 is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low supply-cycle reset; clears volatile state only |
| fuse_rst_n | input | 1 | Asynchronous active-low virgin-die reset; clears the fuse storage |
| mode | input | 2 | 0 run, 1 trial, 2 program, 3 reserved (treated as run) |
| reg_sel | input | 3 | 1 gain, 2 zero, 3 carrier, 6 lock; other values unmapped |
| code | input | 10 | Addressed code for a load or a blow |
| code_load | input | 1 | Load `code` into the selected trial code |
| blow_req | input | 1 | Request to blow the single fuse bit given by `code` |
| gain_trim | output | 9 | Effective gain trim |
| zero_trim | output | 9 | Effective zero-field duty trim |
| carrier_trim | output | 5 | Effective carrier trim |
| locked | output | 1 | Lock fuse state |
| blow_err | output | 1 | One-cycle flag for a refused blow request |

## Verification
The assertions watch four things on every cycle. Fuse storage only ever gains bits, and at most one per cycle. A trial code changes only after a load strobe and stays frozen once locked. `locked` never falls, and `blow_err` only follows a blow request. Other behaviour depends on a chosen sequence and only the bench's scenarios can show it. This covers the legality of a specific code and select, OR-merging of fuse and trial values, bit accumulation in either order across supply cycles, and the lock freezing later requests.

// File: rtl/fuse_trim_pkg.sv
package fuse_trim_pkg;
  localparam int CODE_W  = 10;
  localparam int SEL_W   = 3;
  localparam int GAIN_W  = 9;
  localparam int ZERO_W  = 9;
  localparam int CARR_W  = 5;
  localparam int N_DATA  = 3;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_TRIAL = 2'd1,
    MODE_PROG  = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  localparam logic [SEL_W-1:0]  SEL_LOCK  = 3'd6;
  localparam logic [CODE_W-1:0] LOCK_CODE = 10'd512;
endpackage

// File: rtl/fuse_trim_cell.sv
module fuse_trim_cell #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fuse_rst_n,
  input  logic         locked,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  input  logic         blow_en,
  input  logic [W-1:0] blow_code,
  output logic [W-1:0] eff
);
  logic [W-1:0] fuse_q, fuse_d;
  logic [W-1:0] trial_q, trial_d;

  always_comb begin
    fuse_d = fuse_q;
    if (blow_en) fuse_d = fuse_q | blow_code;
  end

  always_comb begin
    trial_d = trial_q;
    if (wr_en) trial_d = wr_code;
  end

  always_ff @(posedge clk or negedge fuse_rst_n) begin
    if (!fuse_rst_n) fuse_q <= '0;
    else if (blow_en) fuse_q <= fuse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trial_q <= '0;
    else if (wr_en) trial_q <= trial_d;
  end

  assign eff = fuse_q | trial_q;

  // R5
  fuse_monotonic_chk: assert property (@(posedge clk) disable iff (!fuse_rst_n)
    1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q)));

  // R4
  one_bit_per_blow_chk: assert property (@(posedge clk) disable iff (!fuse_rst_n)
    1'b1 |=> ($countones(fuse_q ^ $past(fuse_q)) <= 1));

  // R3
  trial_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(trial_q));

  // R7
  trial_frozen_locked_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_rst_n)
    locked |=> $stable(trial_q));
endmodule

// File: rtl/fuse_blow_decode.sv
module fuse_blow_decode
  import fuse_trim_pkg::*;
#(
  parameter int W_GAIN = GAIN_W,
  parameter int W_ZERO = ZERO_W,
  parameter int W_CARR = CARR_W
) (
  input  mode_e              mode,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [CODE_W-1:0]  code,
  input  logic               code_load,
  input  logic               blow_req,
  input  logic               locked,
  output logic [N_DATA-1:0]  wr_hit,
  output logic [N_DATA-1:0]  blow_hit,
  output logic               lock_hit,
  output logic               blow_bad
);
  function automatic int width_of(int idx);
    case (idx)
      0:       return W_GAIN;
      1:       return W_ZERO;
      default: return W_CARR;
    endcase
  endfunction

  logic code_single;
  logic prog_open;
  logic load_open;

  always_comb begin
    code_single = (code != '0) && ((code & (code - 1'b1)) == '0);
    prog_open   = blow_req && (mode == MODE_PROG) && !locked;
    load_open   = code_load && !locked &&
                  ((mode == MODE_TRIAL) || (mode == MODE_PROG));
  end

  for (genvar i = 0; i < N_DATA; i++) begin : g_reg
    localparam int WI = width_of(i);
    localparam logic [SEL_W-1:0] SEL_I = SEL_W'(i + 1);
    logic fits;
    always_comb begin
      fits        = ((code >> WI) == '0);
      wr_hit[i]   = load_open && (reg_sel == SEL_I);
      blow_hit[i] = prog_open && (reg_sel == SEL_I) && code_single && fits;
    end
  end

  always_comb begin
    lock_hit = prog_open && (reg_sel == SEL_LOCK) && (code == LOCK_CODE);
    blow_bad = blow_req && !(|blow_hit) && !lock_hit;
  end
endmodule

// File: rtl/fuse_trim_bank.sv
module fuse_trim_bank
  import fuse_trim_pkg::*;
#(
  parameter int W_GAIN = GAIN_W,
  parameter int W_ZERO = ZERO_W,
  parameter int W_CARR = CARR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fuse_rst_n,
  input  logic [1:0]         mode,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [CODE_W-1:0]  code,
  input  logic               code_load,
  input  logic               blow_req,
  output logic [W_GAIN-1:0]  gain_trim,
  output logic [W_ZERO-1:0]  zero_trim,
  output logic [W_CARR-1:0]  carrier_trim,
  output logic               locked,
  output logic               blow_err
);
  localparam int MAXW = (W_GAIN > W_ZERO) ? ((W_GAIN > W_CARR) ? W_GAIN : W_CARR)
                                          : ((W_ZERO > W_CARR) ? W_ZERO : W_CARR);

  function automatic int width_of(int idx);
    case (idx)
      0:       return W_GAIN;
      1:       return W_ZERO;
      default: return W_CARR;
    endcase
  endfunction

  logic [N_DATA-1:0]           wr_hit, blow_hit;
  logic                        lock_hit, blow_bad;
  logic [N_DATA-1:0][MAXW-1:0] eff_all;
  logic                        lock_eff;
  logic                        err_q, err_d;

  fuse_blow_decode #(
    .W_GAIN(W_GAIN), .W_ZERO(W_ZERO), .W_CARR(W_CARR)
  ) u_dec (
    .mode     (mode_e'(mode)),
    .reg_sel  (reg_sel),
    .code     (code),
    .code_load(code_load),
    .blow_req (blow_req),
    .locked   (lock_eff),
    .wr_hit   (wr_hit),
    .blow_hit (blow_hit),
    .lock_hit (lock_hit),
    .blow_bad (blow_bad)
  );

  for (genvar i = 0; i < N_DATA; i++) begin : g_cell
    localparam int WI = width_of(i);
    logic [WI-1:0] eff_w;
    fuse_trim_cell #(.W(WI)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .fuse_rst_n(fuse_rst_n),
      .locked    (lock_eff),
      .wr_en     (wr_hit[i]),
      .wr_code   (code[WI-1:0]),
      .blow_en   (blow_hit[i]),
      .blow_code (code[WI-1:0]),
      .eff       (eff_w)
    );
    assign eff_all[i] = MAXW'(eff_w);
  end

  fuse_trim_cell #(.W(1)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .fuse_rst_n(fuse_rst_n),
    .locked    (lock_eff),
    .wr_en     (1'b0),
    .wr_code   (1'b0),
    .blow_en   (lock_hit),
    .blow_code (1'b1),
    .eff       (lock_eff)
  );

  always_comb err_d = blow_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign gain_trim    = eff_all[0][W_GAIN-1:0];
  assign zero_trim    = eff_all[1][W_ZERO-1:0];
  assign carrier_trim = eff_all[2][W_CARR-1:0];
  assign locked       = lock_eff;
  assign blow_err     = err_q;

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!fuse_rst_n)
    locked |=> locked);

  // R6
  err_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blow_err |-> $past(blow_req));

  // R7
  locked_blow_flags_chk: assert property (@(posedge clk) disable iff (!rst_n || !fuse_rst_n)
    (locked && blow_req) |=> blow_err);

  // R1
  err_idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !blow_err);
endmodule

// File: tb/fuse_trim_bank_bench.sv
`timescale 1ns/1ps
module fuse_trim_bank_bench;
  logic       clk;
  logic       rst_n, fuse_rst_n;
  logic [1:0] mode;
  logic [2:0] reg_sel;
  logic [9:0] code;
  logic       code_load, blow_req;
  logic [8:0] gain_trim, zero_trim;
  logic [4:0] carrier_trim;
  logic       locked, blow_err;

  fuse_trim_bank u_fuse_trim_bank (
    .clk(clk), .rst_n(rst_n), .fuse_rst_n(fuse_rst_n), .mode(mode),
    .reg_sel(reg_sel), .code(code), .code_load(code_load), .blow_req(blow_req),
    .gain_trim(gain_trim), .zero_trim(zero_trim), .carrier_trim(carrier_trim),
    .locked(locked), .blow_err(blow_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 0;
  string cur_req = "R1";

  int m_fuse [4];
  int m_trial[3];
  int m_err;
  int m_w[3] = '{9, 9, 5};

  task automatic model_edge();
    int lk, legal, idx, ones, newerr;
    lk = (m_fuse[3] != 0);
    ones = $countones(code);
    legal = 0;
    idx = -1;
    if (blow_req && mode == 2 && !lk) begin
      if (reg_sel >= 1 && reg_sel <= 3) begin
        idx = reg_sel - 1;
        if (ones == 1 && code < (1 << m_w[idx])) legal = 1;
      end else if (reg_sel == 6 && code == 512) begin
        idx = 3;
        legal = 1;
      end
    end
    newerr = (blow_req && !legal) ? 1 : 0;
    if (fuse_rst_n && legal) m_fuse[idx] = m_fuse[idx] | ((idx == 3) ? 1 : int'(code));
    if (rst_n && code_load && !lk && (mode == 1 || mode == 2) &&
        reg_sel >= 1 && reg_sel <= 3)
      m_trial[reg_sel-1] = int'(code) & ((1 << m_w[reg_sel-1]) - 1);
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) m_trial[k] = 0;
      m_err = 0;
    end else m_err = newerr;
    if (!fuse_rst_n) for (int k = 0; k < 4; k++) m_fuse[k] = 0;
  endtask

  task automatic cmp(string name, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, name, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp("gain_trim",    int'(gain_trim),    m_fuse[0] | m_trial[0]);
    cmp("zero_trim",    int'(zero_trim),    m_fuse[1] | m_trial[1]);
    cmp("carrier_trim", int'(carrier_trim), m_fuse[2] | m_trial[2]);
    cmp("locked",       int'(locked),       m_fuse[3]);
    cmp("blow_err",     int'(blow_err),     m_err);
  endtask

  task automatic load(int md, int sel, int c);
    mode = 2'(md); reg_sel = 3'(sel); code = 10'(c); code_load = 1'b1;
    tick();
    code_load = 1'b0;
    tick();
  endtask

  task automatic blow(int md, int sel, int c);
    mode = 2'(md); reg_sel = 3'(sel); code = 10'(c); blow_req = 1'b1;
    tick();
    blow_req = 1'b0;
    tick();
    tick();
  endtask

  task automatic supply_cycle();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic expect_direct(string name, int act, int exp);
    cmp(name, act, exp);
  endtask

  initial begin
    rst_n = 1'b0; fuse_rst_n = 1'b0; mode = 2'd0; reg_sel = 3'd0;
    code = '0; code_load = 1'b0; blow_req = 1'b0;
    for (int k = 0; k < 4; k++) m_fuse[k] = 0;
    for (int k = 0; k < 3; k++) m_trial[k] = 0;
    m_err = 0;

    cur_req = "R1";
    tick(); tick();
    rst_n = 1'b1; fuse_rst_n = 1'b1;
    tick();
    expect_direct("reset gain", int'(gain_trim), 0);

    cur_req = "R3";
    load(1, 1, 'h1A5);
    load(1, 2, 'h0F0);
    load(2, 3, 'h3FF);
    expect_direct("carrier truncated", int'(carrier_trim), 31);
    load(0, 1, 'h003);
    load(3, 2, 'h001);
    load(1, 5, 'h0AA);
    expect_direct("run-mode load ignored", int'(gain_trim), 'h1A5);

    cur_req = "R2";
    blow(2, 1, 1);
    blow(2, 2, 'h100);
    expect_direct("or of fuse and trial", int'(zero_trim), 'h1F0);

    cur_req = "R8";
    supply_cycle();
    expect_direct("fuse survives supply cycle", int'(gain_trim), 1);
    expect_direct("zero fuse only", int'(zero_trim), 'h100);

    cur_req = "R5";
    blow(2, 3, 2);
    supply_cycle();
    blow(2, 3, 1);
    expect_direct("carrier accumulates to 3", int'(carrier_trim), 3);
    blow(2, 2, 4);
    supply_cycle();
    blow(2, 2, 1);
    expect_direct("zero gains code 5", int'(zero_trim), 'h105);

    cur_req = "R6";
    blow(2, 1, 5);
    blow(1, 1, 2);
    blow(2, 1, 512);
    blow(2, 3, 32);
    blow(2, 2, 0);
    blow(0, 3, 4);
    expect_direct("illegal blows leave gain", int'(gain_trim), 1);

    cur_req = "R9";
    blow(2, 4, 1);
    blow(2, 0, 2);
    blow(2, 7, 1);

    cur_req = "R4";
    blow(2, 1, 256);
    expect_direct("top gain bit", int'(gain_trim), 257);

    cur_req = "R7";
    blow(2, 6, 256);
    blow(2, 6, 512);
    expect_direct("lock set", int'(locked), 1);
    load(1, 1, 'h0FF);
    load(2, 3, 'h010);
    blow(2, 1, 2);
    blow(2, 6, 512);
    expect_direct("locked gain frozen", int'(gain_trim), 257);

    cur_req = "R8";
    supply_cycle();
    expect_direct("lock survives supply cycle", int'(locked), 1);

    cur_req = "R1";
    fuse_rst_n = 1'b0;
    tick();
    fuse_rst_n = 1'b1;
    tick();
    expect_direct("virgin die unlocked", int'(locked), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule